// File: doc/BRIEF.md
# UART Receive FIFO with Character Timeout

This block buffers bytes delivered by a UART receive shift register until the CPU reads them. It stores up to sixteen bytes in arrival order and raises a data-ready interrupt once the number of buffered bytes reaches a level chosen by a 2-bit code. A byte that arrives when all sixteen slots are taken is dropped, and a sticky overrun flag records the loss. A status-read strobe clears that flag.

The chosen level can sit above the number of bytes left at the end of a burst. A character timeout covers this case. A one-cycle tick marks each elapsed character time. When the buffer holds data and neither side has touched it for four such ticks, the timeout interrupt is raised. The timeout stops, and its count restarts, when the CPU takes a byte or when the receiver adds one.

Top module: `uart_rx_fifo_tmo`

## Requirements
- R1: After reset the FIFO is empty, `level_o` is 0, `rd_data_o` is 0, and `data_irq_o`, `tmo_irq_o` and `overrun_o` are low.
- R2: Accepted bytes are returned in arrival order. A CPU read of a non-empty FIFO presents the oldest byte on `rd_data_o` from the clock edge that samples `rd_i`, and the value holds until the next effective read.
- R3: `trig_sel_i` selects a trigger level: code 0 gives 1 byte, 1 gives 4, 2 gives 8 and 3 gives 14. `data_irq_o` is high exactly when `rx_ie_i` is high and `level_o` is at or above the selected level.
- R4: The FIFO holds at most 16 bytes. A byte strobed in while 16 are stored and no read occurs in the same cycle is not stored. If a read and a received byte coincide at full, both take effect and the level stays at 16.
- R5: A received byte that is not stored sets `overrun_o`. The flag stays set until `stat_rd_i` is sampled high. If a lost byte and `stat_rd_i` fall in the same cycle, the flag is set.
- R6: `data_irq_o` falls in the cycle after the read that takes `level_o` below the selected level.
- R7: When the FIFO is non-empty and neither an effective read nor a stored byte occurs while four `char_tick_i` pulses are sampled, `tmo_irq_o` rises after the fourth pulse, provided `rx_ie_i` is high.
- R8: An effective CPU read or a stored byte clears `tmo_irq_o` and restarts the tick count from zero.
- R9: A read of an empty FIFO leaves `rd_data_o`, `level_o` and all flags unchanged.
- R10: Ticks that arrive while the FIFO is empty are not counted toward the timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_vld_i | input | 1 | Strobe: a received byte is on `rx_byte_i` |
| rx_byte_i | input | 8 | Byte from the receive shift register |
| rd_i | input | 1 | CPU read strobe for the FIFO |
| stat_rd_i | input | 1 | CPU status-read strobe; clears the overrun flag |
| trig_sel_i | input | 2 | Trigger-level code (0:1, 1:4, 2:8, 3:14) |
| rx_ie_i | input | 1 | Receive interrupt enable |
| char_tick_i | input | 1 | One pulse per character time |
| rd_data_o | output | 8 | Byte returned by the last effective read |
| level_o | output | 5 | Number of stored bytes |
| data_irq_o | output | 1 | Trigger-level data interrupt |
| tmo_irq_o | output | 1 | Character timeout interrupt |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
The bench targets the full boundary. It strobes bytes in past sixteen, which would expose a FIFO that overwrites its oldest entry or lets its level reach 17. It also makes a read and a received byte coincide at full; a design that discards that byte would raise a false overrun. The timeout is exercised with three ticks followed by a read or a received byte and then four more ticks. A timer that is not restarted by one of the two sides would fire early. A timer that counts while the FIFO is empty would fire right after the next byte arrives. Empty-FIFO reads, same-cycle set and clear of the overrun flag, and each of the four trigger codes are checked against a behavioural queue model on every clock, so a wrong level map or a late falling edge of the data interrupt shows up as a mismatch.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [1:0] {
        TRIG_ONE      = 2'd0,
        TRIG_QUARTER  = 2'd1,
        TRIG_HALF     = 2'd2,
        TRIG_NEARFULL = 2'd3
    } trig_code_e;

    function automatic int unsigned trig_level(input logic [1:0] code);
        case (trig_code_e'(code))
            TRIG_ONE:      trig_level = 1;
            TRIG_QUARTER:  trig_level = 4;
            TRIG_HALF:     trig_level = 8;
            default:       trig_level = 14;
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          push_i,
    input  logic [W-1:0]  din_i,
    input  logic          pop_i,
    output logic [CW-1:0] count_o,
    output logic [W-1:0]  dout_o
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
        logic [W-1:0]            dout;
    } store_t;

    store_t st_d, st_q;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        ptr_next = (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (pop_i) begin
            st_d.dout = st_q.mem[st_q.rp];
            st_d.rp   = ptr_next(st_q.rp);
        end
        if (push_i) begin
            st_d.mem[st_q.wp] = din_i;
            st_d.wp           = ptr_next(st_q.wp);
        end
        case ({push_i, pop_i})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign count_o = st_q.cnt;
    assign dout_o  = st_q.dout;

endmodule

// File: rtl/rxq_tmo.sv
module rxq_tmo #(
    parameter int TMO_CHARS = 4,
    localparam int TW       = $clog2(TMO_CHARS + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic touch_i,
    input  logic occupied_i,
    input  logic tick_i,
    output logic expired_o
);

    typedef struct packed {
        logic [TW-1:0] ticks;
    } tmo_t;

    tmo_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (touch_i || !occupied_i) begin
            tm_d.ticks = '0;
        end else if (tick_i && (tm_q.ticks != TW'(TMO_CHARS))) begin
            tm_d.ticks = tm_q.ticks + TW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tm_q <= '0;
        else         tm_q <= tm_d;
    end

    assign expired_o = (tm_q.ticks == TW'(TMO_CHARS));

endmodule

// File: rtl/uart_rx_fifo_tmo.sv
module uart_rx_fifo_tmo #(
    parameter int DEPTH     = 16,
    parameter int W         = 8,
    parameter int TMO_CHARS = 4,
    localparam int CW       = $clog2(DEPTH + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          rx_vld_i,
    input  logic [W-1:0]  rx_byte_i,
    input  logic          rd_i,
    input  logic          stat_rd_i,
    input  logic [1:0]    trig_sel_i,
    input  logic          rx_ie_i,
    input  logic          char_tick_i,
    output logic [W-1:0]  rd_data_o,
    output logic [CW-1:0] level_o,
    output logic          data_irq_o,
    output logic          tmo_irq_o,
    output logic          overrun_o
);

    typedef struct packed {
        logic ovr;
    } flag_t;

    flag_t fl_d, fl_q;

    logic [CW-1:0] count;
    logic          rd_ok;
    logic          wr_ok;
    logic          lost;
    logic          expired;
    logic [CW-1:0] trig_lvl;

    assign rd_ok = rd_i && (count != '0);
    assign wr_ok = rx_vld_i && ((count != CW'(DEPTH)) || rd_ok);
    assign lost  = rx_vld_i && !wr_ok;

    rxq_store #(.DEPTH(DEPTH), .W(W)) store_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .push_i  (wr_ok),
        .din_i   (rx_byte_i),
        .pop_i   (rd_ok),
        .count_o (count),
        .dout_o  (rd_data_o)
    );

    rxq_tmo #(.TMO_CHARS(TMO_CHARS)) tmo_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .touch_i    (rd_ok || wr_ok),
        .occupied_i (count != '0),
        .tick_i     (char_tick_i),
        .expired_o  (expired)
    );

    always_comb begin
        fl_d = fl_q;
        if (lost)           fl_d.ovr = 1'b1;
        else if (stat_rd_i) fl_d.ovr = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fl_q <= '0;
        else         fl_q <= fl_d;
    end

    assign trig_lvl   = CW'(rxq_pkg::trig_level(trig_sel_i));
    assign level_o    = count;
    assign data_irq_o = rx_ie_i && (count >= trig_lvl);
    assign tmo_irq_o  = rx_ie_i && expired && (count != '0);
    assign overrun_o  = fl_q.ovr;

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          rx_vld_i,
    input logic          rd_i,
    input logic          stat_rd_i,
    input logic          rx_ie_i,
    input logic [W-1:0]  rd_data_o,
    input logic [CW-1:0] level_o,
    input logic          data_irq_o,
    input logic          tmo_irq_o,
    input logic          overrun_o
);

    assert_level_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        level_o <= CW'(DEPTH));

    assert_full_no_grow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (level_o == CW'(DEPTH)) && !rd_i |=> level_o == CW'(DEPTH));

    assert_ovr_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_vld_i && (level_o == CW'(DEPTH)) && !rd_i |=> overrun_o);

    assert_ovr_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        overrun_o && !stat_rd_i |=> overrun_o);

    assert_irq_gated_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rx_ie_i |-> !data_irq_o && !tmo_irq_o);

    assert_tmo_read_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_i && (level_o != '0) |=> !tmo_irq_o);

    assert_empty_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_i && (level_o == '0) && !rx_vld_i |=> $stable(rd_data_o) && (level_o == '0));

    assert_no_tmo_empty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (level_o == '0) |-> !tmo_irq_o);

endmodule

bind uart_rx_fifo_tmo rxq_chk #(.DEPTH(DEPTH), .W(W)) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_vld_i   (rx_vld_i),
    .rd_i       (rd_i),
    .stat_rd_i  (stat_rd_i),
    .rx_ie_i    (rx_ie_i),
    .rd_data_o  (rd_data_o),
    .level_o    (level_o),
    .data_irq_o (data_irq_o),
    .tmo_irq_o  (tmo_irq_o),
    .overrun_o  (overrun_o)
);

// File: tb/uart_rx_fifo_tmo_tb.sv
module uart_rx_fifo_tmo_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_vld = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rd = 1'b0;
    logic       stat_rd = 1'b0;
    logic [1:0] trig = 2'd0;
    logic       ie = 1'b1;
    logic       tick = 1'b0;
    logic [7:0] rd_data;
    logic [4:0] level;
    logic       data_irq, tmo_irq, overrun;

    always #5 clk = ~clk;

    uart_rx_fifo_tmo dut_i (
        .clk_i(clk), .rst_ni(rst_n), .rx_vld_i(rx_vld), .rx_byte_i(rx_byte),
        .rd_i(rd), .stat_rd_i(stat_rd), .trig_sel_i(trig), .rx_ie_i(ie),
        .char_tick_i(tick), .rd_data_o(rd_data), .level_o(level),
        .data_irq_o(data_irq), .tmo_irq_o(tmo_irq), .overrun_o(overrun)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // behavioural reference model
    logic [7:0] mq[$];
    logic [7:0] m_last = 8'h00;
    bit         m_ovr = 1'b0;
    int         m_tc = 0;

    function automatic int lvl_of(input logic [1:0] c);
        return (c == 2'd0) ? 1 : (c == 2'd1) ? 4 : (c == 2'd2) ? 8 : 14;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mq.delete();
            m_last = 8'h00; m_ovr = 1'b0; m_tc = 0;
        end else begin
            bit r_ok, w_ok; int sz;
            sz   = mq.size();
            r_ok = rd && (sz > 0);
            w_ok = rx_vld && ((sz < 16) || r_ok);
            if (r_ok) m_last = mq.pop_front();
            if (w_ok) mq.push_back(rx_byte);
            if (rx_vld && !w_ok) m_ovr = 1'b1;
            else if (stat_rd)    m_ovr = 1'b0;
            if (r_ok || w_ok || sz == 0) m_tc = 0;
            else if (tick && m_tc < 4)   m_tc = m_tc + 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 level", int'(level), mq.size());
            chk("R2 rd_data", int'(rd_data), int'(m_last));
            chk("R5 overrun", int'(overrun), int'(m_ovr));
            chk("R3 data_irq", int'(data_irq), int'(ie && (mq.size() >= lvl_of(trig))));
            chk("R7 tmo_irq", int'(tmo_irq), int'(ie && m_tc == 4 && mq.size() > 0));
        end
    end

    task automatic step();
        @(posedge clk); #2;
        rx_vld = 1'b0; rd = 1'b0; stat_rd = 1'b0; tick = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        rx_vld = 1'b1; rx_byte = b; step();
    endtask

    task automatic pop();
        rd = 1'b1; step();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; step(); step();
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: reset values
        chk("R1 level", int'(level), 0);
        chk("R1 irqs", int'({data_irq, tmo_irq, overrun}), 0);
        chk("R1 rd_data", int'(rd_data), 0);
        rst_n = 1'b1;
        step();

        // R2 ordering, R3 code 0
        push(8'hA1); push(8'hB2); push(8'hC3);
        chk("R3 irq at level 1", int'(data_irq), 1);
        pop(); chk("R2 first", int'(rd_data), 8'hA1);
        pop(); chk("R2 second", int'(rd_data), 8'hB2);
        pop(); chk("R2 third", int'(rd_data), 8'hC3);

        // R9 empty read
        pop(); chk("R9 empty read keeps data", int'(rd_data), 8'hC3);
        chk("R9 empty read keeps level", int'(level), 0);

        // R3 code 1, R6 fall
        trig = 2'd1;
        for (int i = 0; i < 3; i++) push(8'(i + 16));
        chk("R3 below 4", int'(data_irq), 0);
        push(8'h44);
        chk("R3 at 4", int'(data_irq), 1);
        pop();
        chk("R6 falls after read", int'(data_irq), 0);
        while (level != 0) pop();

        // R4/R5 full, overrun, coincident read+write
        trig = 2'd3;
        for (int i = 0; i < 16; i++) push(8'(i + 32));
        chk("R3 code 3 at 16", int'(data_irq), 1);
        push(8'hEE);
        chk("R4 no growth", int'(level), 16);
        chk("R5 set", int'(overrun), 1);
        step();
        chk("R5 sticky", int'(overrun), 1);
        stat_rd = 1'b1; step();
        chk("R5 cleared", int'(overrun), 0);
        rx_vld = 1'b1; rx_byte = 8'h77; rd = 1'b1; step();
        chk("R4 read+write at full", int'(level), 16);
        chk("R5 no overrun on read+write", int'(overrun), 0);
        rx_vld = 1'b1; rx_byte = 8'h78; stat_rd = 1'b1; step();
        chk("R5 set wins over clear", int'(overrun), 1);
        stat_rd = 1'b1; step();
        while (level != 2) pop();

        // R7 timeout, R8 restart
        trig = 2'd2;
        ticks(3);
        chk("R7 not yet", int'(tmo_irq), 0);
        ticks(1);
        chk("R7 fires", int'(tmo_irq), 1);
        pop();
        chk("R8 read clears", int'(tmo_irq), 0);
        ticks(3); push(8'h5A); ticks(3);
        chk("R8 byte restarts", int'(tmo_irq), 0);
        ticks(1);
        chk("R7 fires after restart", int'(tmo_irq), 1);
        ie = 1'b0; step();
        chk("R7 gated by enable", int'(tmo_irq), 0);
        ie = 1'b1;
        while (level != 0) pop();

        // R10 ticks while empty
        ticks(5); push(8'h99);
        chk("R10 no early timeout", int'(tmo_irq), 0);
        ticks(3);
        chk("R10 still counting", int'(tmo_irq), 0);
        pop();

        // mixed random traffic, compared every cycle
        for (int i = 0; i < 4000; i++) begin
            rx_vld  = ($urandom_range(99) < 45);
            rx_byte = 8'($urandom);
            rd      = ($urandom_range(99) < 35);
            stat_rd = ($urandom_range(99) < 5);
            tick    = ($urandom_range(99) < 25);
            if ($urandom_range(99) < 3) trig = 2'($urandom);
            if ($urandom_range(99) < 2) ie = ~ie;
            @(posedge clk); #2;
        end
        rx_vld = 1'b0; rd = 1'b0; stat_rd = 1'b0; tick = 1'b0;
        step();
        finish_run();
    end

endmodule